// File: doc/BRIEF.md
# Lane-Parallel Rounding Variable Shift Unit

This unit is one execution stage of a vector datapath. It takes an unsigned source vector and a second vector that holds a signed shift amount for each lane. Each lane is shifted on its own: a zero or positive amount shifts the element left and drops the bits that leave the lane. A negative amount shifts it right by the magnitude and rounds to nearest by adding half of the last discarded weight first.

A 2-bit element-size code selects lanes of 8, 16, 32 or 64 bits. A width bit chooses a 64-bit or a full 128-bit vector. A form select picks a one-element scalar operation instead. Encodings that the operation does not define are flagged and give no valid result.

Every lane has the same datapath depth for all data and all amounts, so the latency is the same for every operand value. The result, the valid flag and the undefined flag are registered one cycle after the request.

Top module: `vshift_round_unit`

## Requirements
- R1: `size_code` 0, 1, 2, 3 selects lanes of 8, 16, 32, 64 bits. Lane i occupies bits [i*W +: W] of both operands and of the result.
- R2: In vector form (`scalar_form`=0), `q_wide`=1 processes all 128 bits. `q_wide`=0 processes only the low 64 bits.
- R3: In vector form, `size_code`=3 with `q_wide`=0 is undefined. One cycle later `out_undef`=1, `out_valid`=0 and `out_result` is all zero.
- R4: In scalar form (`scalar_form`=1) exactly one 64-bit element in bits [63:0] is processed, and only `size_code`=3 is legal. Any other size gives `out_undef`=1 and `out_valid`=0 one cycle later.
- R5: A lane's shift amount is the low 8 bits of the matching lane of `op_amt`, read as two's complement. The higher bits of that lane have no effect.
- R6: An amount of 0 or more shifts the element left, keeping the low W bits. An amount of W or more gives 0.
- R7: An amount of -n shifts right by n with rounding: the result is (element + 2^(n-1)) >> n. The sum is formed one bit wider than the element, so the carry is kept.
- R8: A right shift by more than W gives 0. A right shift by exactly W gives the element's most significant bit.
- R9: In 64-bit vector form and in scalar form, result bits [127:64] are zero, whatever the operands hold there.
- R10: `out_valid` and `out_undef` follow `in_valid` by exactly one clock, for any data. A cycle without `in_valid` leaves both low in the next cycle. Synchronous active-high `rst` clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_data | input | 128 | Unsigned elements to shift |
| op_amt | input | 128 | Per-lane shift amounts (low byte of each lane) |
| size_code | input | 2 | Element size code |
| q_wide | input | 1 | Vector width: 0 = 64 bits, 1 = 128 bits |
| scalar_form | input | 1 | 1 = single 64-bit element form |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 128 | Registered shifted vector |
| out_undef | output | 1 | Registered undefined-encoding flag |

## Verification
Left shifts and rounding right shifts can occur in different lanes of the same vector in the same cycle, because the direction is chosen per lane from the sign of its own amount. The bench sends one byte-lane vector whose amounts alternate between +1 and -1 over identical elements. It then checks that even lanes hold the truncated left-shift value and odd lanes hold the rounded right-shift value. A second case of the same kind pairs the rounding carry out of the top bit (a right shift by exactly the lane width) with a 128-bit operand whose lanes all take that path. It checks that every lane returns the carry as a single set bit.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
   localparam int unsigned SIZE_CODES  = 4;
   localparam int unsigned MIN_ELEM_W  = 8;
   localparam int unsigned MAX_ELEM_W  = MIN_ELEM_W << (SIZE_CODES - 1);

   typedef enum logic [1:0] {
      ESZ_BYTE  = 2'd0,
      ESZ_HALF  = 2'd1,
      ESZ_WORD  = 2'd2,
      ESZ_DWORD = 2'd3
   } esz_e;

   function automatic int unsigned elem_bits(input int unsigned code);
      return MIN_ELEM_W << code;
   endfunction
endpackage

// File: rtl/vsr_lane.sv
module vsr_lane #(
   parameter int unsigned W     = 8,
   parameter int unsigned AMT_W = 8
) (
   input  logic [W-1:0]     elem,
   input  logic [AMT_W-1:0] amt,
   output logic [W-1:0]     res
);
   localparam logic [AMT_W:0] MAG_ONE = (AMT_W+1)'(1);
   localparam logic [AMT_W:0] MAG_TOP = MAG_ONE << AMT_W;

   generate
      if (AMT_W < 2) begin : g_bad_amt
         $error("vsr_lane: AMT_W must be at least 2");
      end
      if (W < 2) begin : g_bad_w
         $error("vsr_lane: W must be at least 2");
      end
   endgenerate

   logic           neg;
   logic [AMT_W:0] mag;
   logic [W:0]     bias;
   logic [W:0]     sum;
   logic [W:0]     rsh_wide;
   logic [W-1:0]   lsh;

   always_comb begin
      neg      = amt[AMT_W-1];
      mag      = neg ? (MAG_TOP - {1'b0, amt}) : {1'b0, amt};
      // rounding bias: half of the lowest discarded weight
      bias     = (mag == '0) ? '0 : ((W+1)'(1) << (mag - MAG_ONE));
      sum      = {1'b0, elem} + bias;
      rsh_wide = sum >> mag;
      lsh      = elem << mag;
      res      = neg ? rsh_wide[W-1:0] : lsh;
   end
endmodule

// File: rtl/vsr_lane_array.sv
module vsr_lane_array #(
   parameter int unsigned DATA_W   = 128,
   parameter int unsigned ESZ_CODE = 0,
   parameter int unsigned AMT_W    = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] amts,
   output logic [DATA_W-1:0] res
);
   localparam int unsigned W     = vsr_pkg::elem_bits(ESZ_CODE);
   localparam int unsigned LANES = DATA_W / W;

   generate
      if (DATA_W % W != 0) begin : g_bad_div
         $error("vsr_lane_array: DATA_W not a multiple of the element width");
      end
      if (AMT_W > W) begin : g_bad_amt
         $error("vsr_lane_array: shift amount field wider than the lane");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         vsr_lane #(.W(W), .AMT_W(AMT_W)) u_lane (
            .elem (data[i*W +: W]),
            .amt  (amts[i*W +: AMT_W]),
            .res  (res[i*W +: W])
         );
      end
   endgenerate
endmodule

// File: rtl/vsr_decode.sv
module vsr_decode (
   input  logic [1:0] size_code,
   input  logic       q_wide,
   input  logic       scalar_form,
   output logic       legal,
   output logic       keep_half,
   output logic       keep_single
);
   always_comb begin
      if (scalar_form) begin
         legal = (size_code == vsr_pkg::ESZ_DWORD);
      end else begin
         legal = !((size_code == vsr_pkg::ESZ_DWORD) && !q_wide);
      end
      keep_single = scalar_form;
      keep_half   = !scalar_form && !q_wide;
   end
endmodule

// File: rtl/vshift_round_unit.sv
module vshift_round_unit #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned AMT_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] op_data,
   input  logic [DATA_W-1:0] op_amt,
   input  logic [1:0]        size_code,
   input  logic              q_wide,
   input  logic              scalar_form,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic              out_undef
);
   localparam int unsigned NSZ    = vsr_pkg::SIZE_CODES;
   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned ONE_W  = vsr_pkg::MAX_ELEM_W;

   generate
      if (DATA_W < 2 * ONE_W || DATA_W % ONE_W != 0) begin : g_bad_width
         $error("vshift_round_unit: DATA_W must be a multiple of 64, at least 128");
      end
   endgenerate

   logic [DATA_W-1:0] size_res [NSZ];
   logic [DATA_W-1:0] picked;
   logic [DATA_W-1:0] masked;
   logic              legal;
   logic              keep_half;
   logic              keep_single;

   vsr_decode u_dec (
      .size_code   (size_code),
      .q_wide      (q_wide),
      .scalar_form (scalar_form),
      .legal       (legal),
      .keep_half   (keep_half),
      .keep_single (keep_single)
   );

   generate
      for (genvar g = 0; g < NSZ; g++) begin : g_size
         vsr_lane_array #(.DATA_W(DATA_W), .ESZ_CODE(g), .AMT_W(AMT_W)) u_arr (
            .data (op_data),
            .amts (op_amt),
            .res  (size_res[g])
         );
      end
   endgenerate

   always_comb begin
      picked = size_res[size_code];
      masked = picked;
      if (keep_single) begin
         masked = {{(DATA_W-ONE_W){1'b0}}, picked[ONE_W-1:0]};
      end else if (keep_half) begin
         masked = {{(DATA_W-HALF_W){1'b0}}, picked[HALF_W-1:0]};
      end
      if (!legal) begin
         masked = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_undef  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid && legal;
         out_undef <= in_valid && !legal;
         if (in_valid) begin
            out_result <= masked;
         end
      end
   end

   // R10: a legal request is answered in exactly one cycle
   a_r10_latency: assert property (@(posedge clk) disable iff (rst)
      (in_valid && legal) |=> (out_valid && !out_undef));

   // R10: no request means no output strobe in the next cycle
   a_r10_idle: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_undef));

   // R3: narrow vector with 64-bit lanes is rejected with a zero result
   a_r3_undef_vec: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !scalar_form && size_code == 2'd3 && !q_wide)
      |=> (out_undef && !out_valid && out_result == '0));

   // R4: scalar form only accepts 64-bit elements
   a_r4_scalar_size: assert property (@(posedge clk) disable iff (rst)
      (in_valid && scalar_form && size_code != 2'd3) |=> (out_undef && !out_valid));

   // R9: upper half is zero for narrow and scalar results
   a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (scalar_form || !q_wide))
      |=> (out_result[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/vshift_round_unit_tb.sv
`timescale 1ns/1ps
module vshift_round_unit_tb;
   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [127:0] op_data;
   logic [127:0] op_amt;
   logic [1:0]   size_code;
   logic         q_wide;
   logic         scalar_form;
   logic         out_valid;
   logic [127:0] out_result;
   logic         out_undef;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   vshift_round_unit u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .op_data(op_data), .op_amt(op_amt), .size_code(size_code),
      .q_wide(q_wide), .scalar_form(scalar_form),
      .out_valid(out_valid), .out_result(out_result), .out_undef(out_undef)
   );

   typedef struct packed {
      logic [1:0]  sz;
      logic        q;
      logic        sc;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] e;
   } vec_t;

   // lane-level stimulus and hand-computed lane result
   localparam vec_t VECS [14] = '{
      '{2'd0, 1'b1, 1'b0, 64'h81,   64'h01,   64'h02},                  // R1 R6
      '{2'd0, 1'b1, 1'b0, 64'h81,   64'hFF,   64'h41},                  // R7
      '{2'd0, 1'b1, 1'b0, 64'h80,   64'hF8,   64'h01},                  // R8 exact W
      '{2'd0, 1'b1, 1'b0, 64'hFF,   64'hF7,   64'h00},                  // R8 beyond W
      '{2'd0, 1'b1, 1'b0, 64'hFF,   64'h08,   64'h00},                  // R6 left by W
      '{2'd1, 1'b1, 1'b0, 64'h1234, 64'hAB04, 64'h2340},                // R5 R6
      '{2'd1, 1'b0, 1'b0, 64'h8001, 64'h00FE, 64'h2000},                // R2 R9 R7
      '{2'd2, 1'b1, 1'b0, 64'hFFFF_FFFF, 64'h0000_00FF, 64'h8000_0000}, // R7 carry
      '{2'd3, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h04,
                          64'h1234_5678_9ABC_DEF0},                     // R1 R6
      '{2'd3, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'hC0, 64'h01},     // R8 64-bit
      '{2'd3, 1'b1, 1'b1, 64'h10,   64'hFC,   64'h01},                  // R4 R9
      '{2'd2, 1'b0, 1'b0, 64'h100,  64'h7F,   64'h00},                  // R6 R2
      '{2'd0, 1'b1, 1'b0, 64'h05,   64'h00,   64'h05},                  // R6 zero
      '{2'd0, 1'b0, 1'b0, 64'h03,   64'hFE,   64'h01}                   // R7 R2
   };

   function automatic logic [127:0] rep(input logic [63:0] v, input int w, input int nbits);
      logic [127:0] r;
      for (int k = 0; k < 128; k++) r[k] = (k < nbits) ? v[k % w] : 1'b0;
      return r;
   endfunction

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] sz, input logic q, input logic sc,
                        input logic [127:0] a, input logic [127:0] b);
      @(negedge clk);
      in_valid = 1'b1; size_code = sz; q_wide = q; scalar_form = sc;
      op_data = a; op_amt = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [127:0] exp_v;
      logic [127:0] amt_v;
      rst = 1'b1; in_valid = 1'b0; op_data = '0; op_amt = '0;
      size_code = 2'd0; q_wide = 1'b1; scalar_form = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 reset valid", {127'b0, out_valid}, 128'd0);
      check("R10 reset undef", {127'b0, out_undef}, 128'd0);
      rst = 1'b0;

      for (int i = 0; i < 14; i++) begin
         int w;
         int nb;
         w  = 8 << VECS[i].sz;
         nb = VECS[i].sc ? 64 : (VECS[i].q ? 128 : 64);
         issue(VECS[i].sz, VECS[i].q, VECS[i].sc,
               rep(VECS[i].a, w, 128), rep(VECS[i].b, w, 128));
         check($sformatf("R1/R6/R7 vec%0d valid", i), {127'b0, out_valid}, 128'd1);
         check($sformatf("R2/R9 vec%0d result", i), out_result, rep(VECS[i].e, w, nb));
      end

      // R10: idle cycle after a request
      @(negedge clk);
      check("R10 idle valid", {126'b0, out_valid, out_undef}, 128'd0);

      // R1 R6 R7: mixed directions per byte lane
      for (int i = 0; i < 16; i++) begin
         amt_v[i*8 +: 8] = (i % 2 == 0) ? 8'h01 : 8'hFF;
         exp_v[i*8 +: 8] = (i % 2 == 0) ? 8'h02 : 8'h41;
      end
      issue(2'd0, 1'b1, 1'b0, {16{8'h81}}, amt_v);
      check("R7 mixed lanes", out_result, exp_v);

      // R8: every halfword lane rounds up by exactly W, with junk above the low byte
      issue(2'd1, 1'b1, 1'b0, {8{16'hC000}}, {8{16'h5AF0}});
      check("R8 carry all lanes", out_result, {8{16'h0001}});

      // R3: vector form 64-bit lanes with Q=0
      issue(2'd3, 1'b0, 1'b0, {2{64'hFFFF}}, '0);
      check("R3 undef flag", {126'b0, out_undef, out_valid}, 128'd2);
      check("R3 zero result", out_result, 128'd0);

      // R4: scalar with byte size
      issue(2'd0, 1'b1, 1'b1, {16{8'h11}}, '0);
      check("R4 scalar undef", {126'b0, out_undef, out_valid}, 128'd2);

      // R10: reset clears a pending valid
      @(negedge clk);
      in_valid = 1'b1; size_code = 2'd0; q_wide = 1'b1; scalar_form = 1'b0;
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      check("R10 reset clears valid", {127'b0, out_valid}, 128'd0);
      rst = 1'b0;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule